// File: doc/BRIEF.md
# Trap-Return Status Update Unit

This block works out what changes in the architectural state when a hart returns from a trap, either from machine level or from supervisor level. The commit stage presents one return request. With it come the current privilege and virtualization state, the 64-bit machine status word, two hypervisor status bits, both exception PCs and a set of static configuration flags. One cycle later the block reports one of two outcomes. On a commit it gives the rewritten status word, the new privilege, the new virtualization state, the rewritten hypervisor previous-virtualization bit and the PC to resume at. On an exception it gives the cause code and leaves the state as it was.

Every input here is control, and the results are due at a fixed latency, so the request is a plain one-cycle strobe with no ready signal. The block never stalls and accepts one request in every cycle. The caller must hold nothing between requests. It takes the registered outputs in the cycle after the strobe and writes them into the real state registers. Swapping the register file and checking memory protection are done elsewhere. This block only raises the fetch fault for an empty protection table.

Status bit positions: supervisor enable at 1, machine enable at 3, supervisor previous-enable at 5, machine previous-enable at 7, supervisor previous-privilege at 8, machine previous-privilege at 12:11, modify-privilege at 17, trap-supervisor-return at 22 and machine previous-virtualization at 39. Privilege codes: user 0, supervisor 1, machine 3.

Top module: `trp_return_unit`

## Requirements
- R1: After reset, `commit_valid` and `exc_valid` are both 0. A cycle with `req_valid` high makes exactly one of the two high in the next cycle. A cycle with `req_valid` low leaves both low in the next cycle.
- R2: A supervisor return (`req_mret`=0) from user privilege raises cause 2 (illegal instruction). This check has the highest priority for a supervisor return.
- R3: When `cfg_has_c` is 0 and bits 1:0 of the selected return PC (`sepc` for a supervisor return, `mepc` for a machine return) are not 00, the request raises cause 0 (misaligned fetch address). This check comes second, after the privilege check. When `cfg_has_c` is 1 it never fires.
- R4: A supervisor return from supervisor privilege with status bit 22 set raises cause 2. This check comes third. At machine privilege, bit 22 is ignored.
- R5: A supervisor return while `cur_virt`=1 and `hs_vtsr`=1 raises cause 22 (virtual instruction). This check has the lowest priority.
- R6: A committed supervisor return copies bit 5 into bit 1, sets bit 5, clears bit 8 and leaves every other status bit except bit 17 unchanged. The new privilege is the old bit 8 (0 or 1), and `ret_pc` equals `sepc`.
- R7: A committed supervisor return clears bit 17 when `cfg_v112` is 1 and keeps it otherwise.
- R8: A committed supervisor return with `cfg_has_h`=1 and `cur_virt`=0 takes `hs_spv` as the new virtualization state and clears `hs_spv_out`. In every other case the virtualization state and `hs_spv_out` stay unchanged.
- R9: A machine return from below machine privilege raises cause 2. This check has the highest priority for a machine return.
- R10: A machine return with `cfg_pmp_en`=1, `cfg_pmp_rules`=0 and status bits 12:11 not equal to 3 raises cause 1 (fetch access fault). This check comes after R3.
- R11: A committed machine return copies bit 7 into bit 3, sets bit 7, writes bits 12:11 with 0 when `cfg_has_u`=1 and with 3 otherwise, clears bit 39 and leaves every other bit except bit 17 unchanged. The new privilege is the old bits 12:11, and `ret_pc` equals `mepc`.
- R12: On a committed machine return, bit 17 is cleared only when `cfg_v112`=1 and the old bits 12:11 are not 3. When `cfg_has_h`=1, the new virtualization state is the old bit 39 AND (old bits 12:11 not equal to 3). Otherwise it is `cur_virt`.
- R13: On an exception, `mstatus_out`, `priv_out`, `virt_out` and `hs_spv_out` repeat the request's inputs and `ret_pc` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Return request strobe |
| req_mret | input | 1 | 1 = machine return, 0 = supervisor return |
| cur_priv | input | 2 | Current privilege |
| cur_virt | input | 1 | Currently virtualized |
| mstatus_in | input | 64 | Machine status word |
| hs_vtsr | input | 1 | Hypervisor trap-supervisor-return bit |
| hs_spv | input | 1 | Hypervisor supervisor previous-virtualization bit |
| sepc | input | XLEN | Supervisor exception PC |
| mepc | input | XLEN | Machine exception PC |
| cfg_has_c | input | 1 | Compressed instructions supported |
| cfg_has_u | input | 1 | User mode supported |
| cfg_has_h | input | 1 | Hypervisor supported |
| cfg_v112 | input | 1 | Privilege spec 1.12 or later |
| cfg_pmp_en | input | 1 | Memory protection unit present |
| cfg_pmp_rules | input | RULE_W | Number of configured protection rules |
| commit_valid | output | 1 | Return committed this cycle |
| exc_valid | output | 1 | Return raised an exception |
| exc_cause | output | 5 | Exception cause code |
| mstatus_out | output | 64 | Updated status word |
| hs_spv_out | output | 1 | Updated supervisor previous-virtualization bit |
| priv_out | output | 2 | New privilege |
| virt_out | output | 1 | New virtualization state |
| ret_pc | output | XLEN | Resume PC |

## Verification
Every result is registered once, so every result is due exactly one clock after the edge that samples `req_valid`. Nothing is due in the cycle after that. The bench drives a request on a falling edge and drops it on the next falling edge, where it reads every output. On the falling edge after that, before it drives the next request, it checks that both outcome strobes are low. The sweep covers privilege, virtualization, both trap bits, PC alignment, the configuration flags, the state of the protection table and the previous-privilege field. It compares each output field with a model written from the requirements.

// File: rtl/trp_pkg.sv
package trp_pkg;
  localparam int ST_W     = 64;
  localparam int B_SIE    = 1;
  localparam int B_MIE    = 3;
  localparam int B_SPIE   = 5;
  localparam int B_MPIE   = 7;
  localparam int B_SPP    = 8;
  localparam int B_MPP_LO = 11;
  localparam int B_MPRV   = 17;
  localparam int B_TSR    = 22;
  localparam int B_MPV    = 39;

  typedef enum logic [1:0] {
    PRIV_U = 2'd0,
    PRIV_S = 2'd1,
    PRIV_R = 2'd2,
    PRIV_M = 2'd3
  } priv_e;

  typedef enum logic [4:0] {
    CAUSE_PC_MISALIGN = 5'd0,
    CAUSE_FETCH_FAULT = 5'd1,
    CAUSE_ILLEGAL     = 5'd2,
    CAUSE_VIRT_INSN   = 5'd22
  } cause_e;

  typedef struct packed {
    logic            exc;
    cause_e          cause;
    logic [ST_W-1:0] status;
    priv_e           priv;
    logic            virt;
    logic            spv;
  } ret_res_t;

  // A return target needs 4-byte alignment unless 2-byte instructions exist.
  function automatic logic pc_misaligned(input logic has_c, input logic [1:0] low);
    return !has_c && (low != 2'b00);
  endfunction
endpackage

// File: rtl/trp_sret_path.sv
module trp_sret_path
  import trp_pkg::*;
(
  input  logic            cur_priv_i_0,
  input  logic [1:0]      cur_priv,
  input  logic            cur_virt,
  input  logic [ST_W-1:0] mstatus_in,
  input  logic            vtsr,
  input  logic            spv,
  input  logic [1:0]      epc_low,
  input  logic            has_c,
  input  logic            has_h,
  input  logic            v112,
  output ret_res_t        res
);
  logic unused_bit;
  assign unused_bit = cur_priv_i_0;

  always_comb begin
    res        = '0;
    res.cause  = CAUSE_ILLEGAL;
    res.status = mstatus_in;
    res.priv   = priv_e'(cur_priv);
    res.virt   = cur_virt;
    res.spv    = spv;
    if (cur_priv == PRIV_U) begin
      res.exc   = 1'b1;
      res.cause = CAUSE_ILLEGAL;
    end else if (pc_misaligned(has_c, epc_low)) begin
      res.exc   = 1'b1;
      res.cause = CAUSE_PC_MISALIGN;
    end else if (mstatus_in[B_TSR] && (cur_priv != PRIV_M)) begin
      res.exc   = 1'b1;
      res.cause = CAUSE_ILLEGAL;
    end else if (cur_virt && vtsr) begin
      res.exc   = 1'b1;
      res.cause = CAUSE_VIRT_INSN;
    end else begin
      res.status[B_SIE]  = mstatus_in[B_SPIE];
      res.status[B_SPIE] = 1'b1;
      res.status[B_SPP]  = 1'b0;
      if (v112) res.status[B_MPRV] = 1'b0;
      res.priv = priv_e'({1'b0, mstatus_in[B_SPP]});
      if (has_h && !cur_virt) begin
        res.virt = spv;
        res.spv  = 1'b0;
      end
    end
  end
endmodule

// File: rtl/trp_mret_path.sv
module trp_mret_path
  import trp_pkg::*;
#(
  parameter int RULE_W = 7
) (
  input  logic              [1:0] cur_priv,
  input  logic                    cur_virt,
  input  logic         [ST_W-1:0] mstatus_in,
  input  logic                    spv,
  input  logic              [1:0] epc_low,
  input  logic                    has_c,
  input  logic                    has_u,
  input  logic                    has_h,
  input  logic                    v112,
  input  logic                    pmp_en,
  input  logic [RULE_W-1:0]       pmp_rules,
  output ret_res_t                res
);
  logic [1:0] tgt;
  logic       tgt_not_m;
  assign tgt       = mstatus_in[B_MPP_LO +: 2];
  assign tgt_not_m = (tgt != PRIV_M);

  always_comb begin
    res        = '0;
    res.cause  = CAUSE_ILLEGAL;
    res.status = mstatus_in;
    res.priv   = priv_e'(cur_priv);
    res.virt   = cur_virt;
    res.spv    = spv;
    if (cur_priv != PRIV_M) begin
      res.exc   = 1'b1;
      res.cause = CAUSE_ILLEGAL;
    end else if (pc_misaligned(has_c, epc_low)) begin
      res.exc   = 1'b1;
      res.cause = CAUSE_PC_MISALIGN;
    end else if (pmp_en && (pmp_rules == '0) && tgt_not_m) begin
      res.exc   = 1'b1;
      res.cause = CAUSE_FETCH_FAULT;
    end else begin
      res.status[B_MIE]        = mstatus_in[B_MPIE];
      res.status[B_MPIE]       = 1'b1;
      res.status[B_MPP_LO +: 2] = has_u ? PRIV_U : PRIV_M;
      res.status[B_MPV]        = 1'b0;
      if (v112 && tgt_not_m) res.status[B_MPRV] = 1'b0;
      res.priv = priv_e'(tgt);
      if (has_h) res.virt = mstatus_in[B_MPV] && tgt_not_m;
    end
  end
endmodule

// File: rtl/trp_return_unit.sv
module trp_return_unit
  import trp_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int RULE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_mret,
  input  logic [1:0]        cur_priv,
  input  logic              cur_virt,
  input  logic [63:0]       mstatus_in,
  input  logic              hs_vtsr,
  input  logic              hs_spv,
  input  logic [XLEN-1:0]   sepc,
  input  logic [XLEN-1:0]   mepc,
  input  logic              cfg_has_c,
  input  logic              cfg_has_u,
  input  logic              cfg_has_h,
  input  logic              cfg_v112,
  input  logic              cfg_pmp_en,
  input  logic [RULE_W-1:0] cfg_pmp_rules,
  output logic              commit_valid,
  output logic              exc_valid,
  output logic [4:0]        exc_cause,
  output logic [63:0]       mstatus_out,
  output logic              hs_spv_out,
  output logic [1:0]        priv_out,
  output logic              virt_out,
  output logic [XLEN-1:0]   ret_pc
);
  ret_res_t s_res, m_res, sel;
  logic     mret_q;

  trp_sret_path u_sret (
    .cur_priv_i_0 (cur_priv[0]),
    .cur_priv     (cur_priv),
    .cur_virt     (cur_virt),
    .mstatus_in   (mstatus_in),
    .vtsr         (hs_vtsr),
    .spv          (hs_spv),
    .epc_low      (sepc[1:0]),
    .has_c        (cfg_has_c),
    .has_h        (cfg_has_h),
    .v112         (cfg_v112),
    .res          (s_res)
  );

  trp_mret_path #(.RULE_W(RULE_W)) u_mret (
    .cur_priv   (cur_priv),
    .cur_virt   (cur_virt),
    .mstatus_in (mstatus_in),
    .spv        (hs_spv),
    .epc_low    (mepc[1:0]),
    .has_c      (cfg_has_c),
    .has_u      (cfg_has_u),
    .has_h      (cfg_has_h),
    .v112       (cfg_v112),
    .pmp_en     (cfg_pmp_en),
    .pmp_rules  (cfg_pmp_rules),
    .res        (m_res)
  );

  assign sel = req_mret ? m_res : s_res;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      commit_valid <= 1'b0;
      exc_valid    <= 1'b0;
      exc_cause    <= '0;
      mstatus_out  <= '0;
      hs_spv_out   <= 1'b0;
      priv_out     <= PRIV_M;
      virt_out     <= 1'b0;
      ret_pc       <= '0;
      mret_q       <= 1'b0;
    end else begin
      commit_valid <= req_valid && !sel.exc;
      exc_valid    <= req_valid && sel.exc;
      if (req_valid) begin
        exc_cause   <= sel.cause;
        mstatus_out <= sel.status;
        hs_spv_out  <= sel.spv;
        priv_out    <= sel.priv;
        virt_out    <= sel.virt;
        ret_pc      <= sel.exc ? '0 : (req_mret ? mepc : sepc);
        mret_q      <= req_mret;
      end
    end
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (commit_valid ^ exc_valid)); // R1
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !(commit_valid || exc_valid)); // R1
  AST_EXC_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (exc_valid -> (mstatus_out == $past(mstatus_in) && priv_out == $past(cur_priv)))); // R13
  AST_SRET_SPP_USER: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_valid && !mret_q) |-> (!mstatus_out[B_SPP] && mstatus_out[B_SPIE])); // R6
  AST_SRET_NOT_MACHINE: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_valid && !mret_q) |-> (priv_out != PRIV_M)); // R6
  AST_MRET_MPV_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_valid && mret_q) |-> (!mstatus_out[B_MPV] && mstatus_out[B_MPIE])); // R11
endmodule

// File: tb/trp_return_unit_tb.sv
module trp_return_unit_tb;
  import trp_pkg::*;
  localparam int XLEN   = 64;
  localparam int RULE_W = 7;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst_n, req_valid, req_mret, cur_virt, hs_vtsr, hs_spv;
  logic [1:0]        cur_priv;
  logic [63:0]       mstatus_in;
  logic [XLEN-1:0]   sepc, mepc;
  logic              cfg_has_c, cfg_has_u, cfg_has_h, cfg_v112, cfg_pmp_en;
  logic [RULE_W-1:0] cfg_pmp_rules;
  logic              commit_valid, exc_valid, hs_spv_out, virt_out;
  logic [4:0]        exc_cause;
  logic [63:0]       mstatus_out;
  logic [1:0]        priv_out;
  logic [XLEN-1:0]   ret_pc;

  trp_return_unit #(.XLEN(XLEN), .RULE_W(RULE_W)) u_dut (.*);

  int   n_chk  = 0;
  int   n_fail = 0;
  logic done   = 1'b0;
  logic [63:0] lfsr = 64'h9E37_79B9_7F4A_7C15;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step_rng();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 7);
    lfsr = lfsr ^ (lfsr << 17);
  endtask

  task automatic model(output logic e, output logic [4:0] cause, output string tag,
                       output logic [63:0] st, output logic [1:0] pr, output logic vt,
                       output logic sp, output logic [63:0] pc);
    logic [63:0] epc;
    logic [1:0]  mpp;
    e = 1'b0; cause = 5'd0; tag = "R1"; st = mstatus_in; pr = cur_priv;
    vt = cur_virt; sp = hs_spv; pc = 64'd0;
    mpp = mstatus_in[12:11];
    if (!req_mret) begin
      epc = sepc;
      if (cur_priv == 2'd0) begin e = 1; cause = 5'd2; tag = "R2"; end
      else if (!cfg_has_c && epc[1:0] != 2'b00) begin e = 1; cause = 5'd0; tag = "R3"; end
      else if (mstatus_in[22] && cur_priv != 2'd3) begin e = 1; cause = 5'd2; tag = "R4"; end
      else if (cur_virt && hs_vtsr) begin e = 1; cause = 5'd22; tag = "R5"; end
      else begin
        st[1] = mstatus_in[5]; st[5] = 1'b1; st[8] = 1'b0;
        if (cfg_v112) st[17] = 1'b0;
        pr = {1'b0, mstatus_in[8]};
        if (cfg_has_h && !cur_virt) begin vt = hs_spv; sp = 1'b0; end
        pc = epc;
      end
    end else begin
      epc = mepc;
      if (cur_priv != 2'd3) begin e = 1; cause = 5'd2; tag = "R9"; end
      else if (!cfg_has_c && epc[1:0] != 2'b00) begin e = 1; cause = 5'd0; tag = "R3"; end
      else if (cfg_pmp_en && cfg_pmp_rules == 0 && mpp != 2'd3) begin e = 1; cause = 5'd1; tag = "R10"; end
      else begin
        st[3] = mstatus_in[7]; st[7] = 1'b1;
        st[12:11] = cfg_has_u ? 2'd0 : 2'd3;
        st[39] = 1'b0;
        if (cfg_v112 && mpp != 2'd3) st[17] = 1'b0;
        pr = mpp;
        if (cfg_has_h) vt = mstatus_in[39] && (mpp != 2'd3);
        pc = epc;
      end
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R1: watchdog actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic        e_exc, e_sp, e_vt;
    logic [4:0]  e_cause;
    logic [63:0] e_st, e_pc, mask17;
    logic [1:0]  e_pr;
    string       tag;
    logic [1:0]  privs [3];
    logic        first;
    privs[0] = 2'd0; privs[1] = 2'd1; privs[2] = 2'd3;
    mask17 = ~(64'd1 << 17);
    first = 1'b1;
    rst_n = 0; req_valid = 0; req_mret = 0; cur_priv = 0; cur_virt = 0;
    mstatus_in = 0; hs_vtsr = 0; hs_spv = 0; sepc = 0; mepc = 0;
    cfg_has_c = 0; cfg_has_u = 0; cfg_has_h = 0; cfg_v112 = 0; cfg_pmp_en = 0;
    cfg_pmp_rules = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    chk("R1 reset commit", {63'd0, commit_valid}, 64'd0);
    chk("R1 reset exc", {63'd0, exc_valid}, 64'd0);
    for (int kind = 0; kind < 2; kind++)
    for (int pi = 0; pi < 3; pi++)
    for (int vi = 0; vi < 2; vi++)
    for (int ts = 0; ts < 2; ts++)
    for (int vs = 0; vs < 2; vs++)
    for (int pl = 0; pl < 4; pl++)
    for (int cc = 0; cc < 2; cc++)
    for (int vv = 0; vv < 2; vv++)
    for (int hh = 0; hh < 2; hh++)
    for (int uu = 0; uu < 2; uu++)
    for (int pm = 0; pm < 3; pm++)
    for (int mp = 0; mp < 3; mp++) begin
      @(negedge clk);
      if (!first) begin
        chk("R1 idle strobes", {62'd0, commit_valid, exc_valid}, 64'd0);
      end
      first = 1'b0;
      step_rng();
      mstatus_in = lfsr;
      mstatus_in[22] = ts[0];
      mstatus_in[12:11] = privs[mp];
      step_rng();
      sepc = {lfsr[63:2], pl[1:0]};
      hs_spv = lfsr[0];
      step_rng();
      mepc = {lfsr[63:2], pl[1:0]};
      req_mret = kind[0]; cur_priv = privs[pi]; cur_virt = vi[0];
      hs_vtsr = vs[0]; cfg_has_c = cc[0]; cfg_v112 = vv[0];
      cfg_has_h = hh[0]; cfg_has_u = uu[0];
      cfg_pmp_en = (pm != 0);
      cfg_pmp_rules = (pm == 1) ? '0 : RULE_W'(1 + (lfsr[15:8] % 63));
      req_valid = 1'b1;
      model(e_exc, e_cause, tag, e_st, e_pr, e_vt, e_sp, e_pc);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R1 outcome", {62'd0, commit_valid, exc_valid}, {62'd0, !e_exc, e_exc});
      if (e_exc) begin
        chk({tag, " cause"}, {59'd0, exc_cause}, {59'd0, e_cause});
        chk("R13 status kept", mstatus_out, mstatus_in);
        chk("R13 priv/virt/spv kept", {60'd0, priv_out, virt_out, hs_spv_out},
            {60'd0, cur_priv, cur_virt, hs_spv});
        chk("R13 pc zero", ret_pc, 64'd0);
      end else begin
        chk(kind ? "R11 status" : "R6 status", mstatus_out & mask17, e_st & mask17);
        chk(kind ? "R12 mprv" : "R7 mprv", {63'd0, mstatus_out[17]}, {63'd0, e_st[17]});
        chk(kind ? "R11 priv" : "R6 priv", {62'd0, priv_out}, {62'd0, e_pr});
        chk(kind ? "R12 virt" : "R8 virt", {63'd0, virt_out}, {63'd0, e_vt});
        chk("R8 spv", {63'd0, hs_spv_out}, {63'd0, e_sp});
        chk(kind ? "R11 pc" : "R6 pc", ret_pc, e_pc);
      end
    end
    @(negedge clk);
    chk("R1 idle strobes", {62'd0, commit_valid, exc_valid}, 64'd0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule